// File: doc/BRIEF.md
# Multiply-Accumulate Unit with HI/LO Accumulator

This block multiplies two 64-bit register operands and adds the product to a private accumulator, or subtracts it. The accumulator is held in two 64-bit registers, HI and LO. A single datapath handles signed and unsigned arithmetic, operands restricted to 16 bits, a wide mode that keeps the whole accumulator in LO, and optional clamping of the result. Each operation also returns a value for a destination register, taken from the new HI or the new LO.

An operation starts when `op_start` is high at a rising clock edge, with the operands and mode flags held valid in that same cycle. The registered outcome appears in the following cycle, marked by `op_done`. If either operand is not written in the extended form that its mode demands, the block raises `op_err`, returns zero and leaves HI and LO untouched.

Top module: `mac_unit`

## Requirements
- R1: While reset (`rst_n` low) is asserted and after it is released, `acc_hi`, `acc_lo`, `rd_val`, `op_done` and `op_err` are all zero.
- R2: `op_done` is high in exactly the cycle that follows each edge at which `op_start` was high. An edge with `op_start` low leaves `acc_hi` and `acc_lo` unchanged.
- R3: The addend depends on the flags. It is 0 when `f_acc` is low. It is the full `acc_lo` when `f_acc` and `f_wide` are both high. Otherwise it is {acc_hi[31:0], acc_lo[31:0]}.
- R4: The product is 64 bits wide. With `f_uns` high it is the unsigned product of rs[31:0] and rt[31:0]. Otherwise it is the signed product of both operands sign-extended from bit 31.
- R5: With `f_sub` high the raw result is the addend minus the product; otherwise it is the addend plus the product. Both are taken modulo 2^64.
- R6: With `f_wide` low, LO becomes the raw result's bits [31:0] sign-extended to 64 bits, and HI becomes its bits [63:32] sign-extended to 64 bits.
- R7: With `f_wide` high, LO becomes the full 64-bit result and HI keeps its previous value.
- R8: With `f_sat` high and `f_uns` low, a result outside the signed 32-bit range becomes 0x000000007FFFFFFF if it is positive and 0xFFFFFFFF80000000 if it is negative.
- R9: With `f_sat` high and `f_uns` high, a result whose bits [63:32] are not all zero becomes all ones in all 64 bits.
- R10: With `f_half` low, an operand is legal only if its value lies in the signed 32-bit range, which means it is a correct sign extension of bit 31.
- R11: With `f_half` high, a legal operand lies in 0..65535 when `f_uns` is high, and in -32768..32767 when `f_uns` is low.
- R12: If either operand is illegal, `op_err` is high with `op_done`, `rd_val` is zero, and HI and LO keep their values.
- R13: On a legal operation, `rd_val` equals the new HI when `f_hi_sel` is high and the new LO otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_start | input | 1 | Launches an operation at this edge |
| rs | input | 64 | First multiplicand |
| rt | input | 64 | Second multiplicand |
| f_acc | input | 1 | Use the accumulator as the addend |
| f_hi_sel | input | 1 | Return HI (1) or LO (0) on rd_val |
| f_uns | input | 1 | Unsigned arithmetic |
| f_sat | input | 1 | Clamp the result |
| f_sub | input | 1 | Subtract the product instead of adding it |
| f_half | input | 1 | Operands restricted to 16 bits |
| f_wide | input | 1 | Whole accumulator kept in LO |
| op_done | output | 1 | Outcome valid in this cycle |
| op_err | output | 1 | Illegal operand detected |
| rd_val | output | 64 | Destination-register value |
| acc_hi | output | 64 | HI accumulator register |
| acc_lo | output | 64 | LO accumulator register |

## Verification
Every result is due one cycle after its launch. The launching edge writes HI, LO, `rd_val`, `op_err` and `op_done` together, so no output lags another. The bench drives each operation on a falling edge and reads all outputs on the next falling edge, half a period after the register update. At that point it compares them with a model that holds its own copy of HI and LO. Operations are launched back to back, which means `op_done` must stay high throughout the sweep. A final idle cycle shows it falling again and the accumulator holding still.

// File: rtl/mac_pkg.sv
package mac_pkg;

   typedef struct packed {
      logic acc;
      logic hi_sel;
      logic uns;
      logic sat;
      logic sub;
      logic half;
      logic wide;
   } mac_flags_t;

endpackage

// File: rtl/mac_opnd_chk.sv
module mac_opnd_chk #(
   parameter int DW = 64,
   parameter int HW = 32,
   parameter int QW = 16
) (
   input  logic [DW-1:0] val,
   input  logic          uns,
   input  logic          half,
   output logic          ok
);
   logic [DW-1:0] canon;

   always_comb begin
      if (half && uns)
         canon = {{(DW-QW){1'b0}}, val[QW-1:0]};
      else if (half)
         canon = {{(DW-QW){val[QW-1]}}, val[QW-1:0]};
      else
         canon = {{(DW-HW){val[HW-1]}}, val[HW-1:0]};
   end

   assign ok = (canon == val);
endmodule

// File: rtl/mac_arith.sv
module mac_arith #(
   parameter int DW = 64,
   parameter int HW = 32
) (
   input  logic [DW-1:0] addend,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          uns,
   input  logic          sub,
   output logic [DW-1:0] raw
);
   logic [DW-1:0] ma, mb, prod;

   // Low DW bits of a DW x DW multiply are the same for both signednesses,
   // so only the extension of the HW-bit inputs differs between modes.
   assign ma   = uns ? {{(DW-HW){1'b0}}, a[HW-1:0]} : {{(DW-HW){a[HW-1]}}, a[HW-1:0]};
   assign mb   = uns ? {{(DW-HW){1'b0}}, b[HW-1:0]} : {{(DW-HW){b[HW-1]}}, b[HW-1:0]};
   assign prod = ma * mb;
   assign raw  = sub ? (addend - prod) : (addend + prod);
endmodule

// File: rtl/mac_sat.sv
module mac_sat #(
   parameter int DW     = 64,
   parameter int HW     = 32,
   parameter bit SAT_EN = 1'b1
) (
   input  logic [DW-1:0] raw,
   input  logic          en,
   input  logic          uns,
   output logic [DW-1:0] res
);
   localparam logic [DW-1:0] POS_MAX = {{(DW-HW+1){1'b0}}, {(HW-1){1'b1}}};
   localparam logic [DW-1:0] NEG_MIN = ~POS_MAX;

   generate
      if (SAT_EN) begin : g_sat
         logic s_ovf, u_ovf;
         assign s_ovf = (raw != {{(DW-HW){raw[HW-1]}}, raw[HW-1:0]});
         assign u_ovf = (raw[DW-1:HW] != '0);
         always_comb begin
            res = raw;
            if (en && !uns && s_ovf)
               res = raw[DW-1] ? NEG_MIN : POS_MAX;
            else if (en && uns && u_ovf)
               res = '1;
         end
      end else begin : g_nosat
         logic unused_ok;
         assign unused_ok = en ^ uns;
         assign res = raw;
      end
   endgenerate
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
   parameter int DW     = 64,
   parameter int HW     = 32,
   parameter int QW     = 16,
   parameter bit SAT_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_start,
   input  logic [63:0]   rs,
   input  logic [63:0]   rt,
   input  logic          f_acc,
   input  logic          f_hi_sel,
   input  logic          f_uns,
   input  logic          f_sat,
   input  logic          f_sub,
   input  logic          f_half,
   input  logic          f_wide,
   output logic          op_done,
   output logic          op_err,
   output logic [63:0]   rd_val,
   output logic [63:0]   acc_hi,
   output logic [63:0]   acc_lo
);
   import mac_pkg::*;

   localparam int NOPS = 2;

   generate
      if (DW != 2*HW) begin : g_bad_dw
         $error("mac_unit: DW must be twice HW");
      end
      if (QW >= HW || QW < 1) begin : g_bad_qw
         $error("mac_unit: QW must lie between 1 and HW-1");
      end
      if (DW != 64) begin : g_bad_port
         $error("mac_unit: ports are fixed at 64 bits");
      end
   endgenerate

   mac_flags_t fl;
   assign fl = '{acc: f_acc, hi_sel: f_hi_sel, uns: f_uns, sat: f_sat,
                 sub: f_sub, half: f_half, wide: f_wide};

   logic [DW-1:0] opnd [NOPS];
   logic [NOPS-1:0] opnd_ok;
   assign opnd[0] = rs;
   assign opnd[1] = rt;

   generate
      for (genvar g = 0; g < NOPS; g++) begin : g_chk
         mac_opnd_chk #(.DW(DW), .HW(HW), .QW(QW)) u_chk (
            .val (opnd[g]),
            .uns (fl.uns),
            .half(fl.half),
            .ok  (opnd_ok[g])
         );
      end
   endgenerate

   logic [DW-1:0] addend, raw, res, nxt_hi, nxt_lo;

   always_comb begin
      if (!fl.acc)
         addend = '0;
      else if (fl.wide)
         addend = acc_lo;
      else
         addend = {acc_hi[HW-1:0], acc_lo[HW-1:0]};
   end

   mac_arith #(.DW(DW), .HW(HW)) u_arith (
      .addend(addend),
      .a     (opnd[0]),
      .b     (opnd[1]),
      .uns   (fl.uns),
      .sub   (fl.sub),
      .raw   (raw)
   );

   mac_sat #(.DW(DW), .HW(HW), .SAT_EN(SAT_EN)) u_sat (
      .raw(raw),
      .en (fl.sat),
      .uns(fl.uns),
      .res(res)
   );

   always_comb begin
      if (fl.wide) begin
         nxt_lo = res;
         nxt_hi = acc_hi;
      end else begin
         nxt_lo = {{(DW-HW){res[HW-1]}}, res[HW-1:0]};
         nxt_hi = {{(DW-HW){res[DW-1]}}, res[DW-1:HW]};
      end
   end

   logic legal;
   assign legal = &opnd_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_hi  <= '0;
         acc_lo  <= '0;
         rd_val  <= '0;
         op_done <= 1'b0;
         op_err  <= 1'b0;
      end else begin
         op_done <= op_start;
         if (op_start) begin
            op_err <= !legal;
            if (legal) begin
               acc_hi <= nxt_hi;
               acc_lo <= nxt_lo;
               rd_val <= fl.hi_sel ? nxt_hi : nxt_lo;
            end else begin
               rd_val <= '0;
            end
         end else begin
            op_err <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
   parameter int DW = 64,
   parameter int HW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          op_start,
   input logic [63:0]   rs,
   input logic          f_hi_sel,
   input logic          f_uns,
   input logic          f_sat,
   input logic          f_half,
   input logic          f_wide,
   input logic          op_done,
   input logic          op_err,
   input logic [63:0]   rd_val,
   input logic [63:0]   acc_hi,
   input logic [63:0]   acc_lo
);
   p_done_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |=> op_done);
   p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !op_start |=> !op_done);
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !op_start |=> ($stable(acc_hi) && $stable(acc_lo)));
   p_wide_hi_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && f_wide) |=> $stable(acc_hi));
   p_sat_signed_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && f_sat && !f_uns && !f_wide) |=>
         (op_err || acc_hi == {DW{acc_lo[HW-1]}}));
   p_sat_unsigned_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && f_sat && f_uns && !f_wide) |=>
         (op_err || acc_hi == '0 || (acc_hi == '1 && acc_lo == '1)));
   p_half_uns_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && f_half && f_uns && rs[DW-1:16] != '0) |=> op_err);
   p_err_holds_acc_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start ##1 op_err) |-> ($stable(acc_hi) && $stable(acc_lo) && rd_val == '0));
   p_rd_select_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && f_hi_sel) ##1 !op_err |-> rd_val == acc_hi);
   p_rd_select_lo_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && !f_hi_sel) ##1 !op_err |-> rd_val == acc_lo);
endmodule

bind mac_unit mac_unit_chk #(.DW(DW), .HW(HW)) u_mac_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .op_start(op_start),
   .rs      (rs),
   .f_hi_sel(f_hi_sel),
   .f_uns   (f_uns),
   .f_sat   (f_sat),
   .f_half  (f_half),
   .f_wide  (f_wide),
   .op_done (op_done),
   .op_err  (op_err),
   .rd_val  (rd_val),
   .acc_hi  (acc_hi),
   .acc_lo  (acc_lo)
);

// File: tb/mac_unit_test.sv
module mac_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;
   localparam int NPAT       = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_start = 1'b0;
   logic [63:0] rs = '0, rt = '0;
   logic        f_acc = 0, f_hi_sel = 0, f_uns = 0, f_sat = 0, f_sub = 0, f_half = 0, f_wide = 0;
   logic        op_done, op_err;
   logic [63:0] rd_val, acc_hi, acc_lo;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit finished = 0;

   logic [63:0] m_hi = '0, m_lo = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mac_unit uut (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .rs(rs), .rt(rt),
      .f_acc(f_acc), .f_hi_sel(f_hi_sel), .f_uns(f_uns), .f_sat(f_sat),
      .f_sub(f_sub), .f_half(f_half), .f_wide(f_wide),
      .op_done(op_done), .op_err(op_err), .rd_val(rd_val),
      .acc_hi(acc_hi), .acc_lo(acc_lo)
   );

   function automatic logic [63:0] pat(int i);
      case (i)
         0: return 64'h0;
         1: return 64'h1;
         2: return 64'hFFFF_FFFF_FFFF_FFFF;
         3: return 64'h7FFF;
         4: return 64'hFFFF_FFFF_FFFF_8000;
         5: return 64'h7FFF_FFFF;
         6: return 64'hFFFF_FFFF_8000_0000;
         7: return 64'h8000_0000;
         8: return 64'h1_0000_0000;
         default: return 64'hFFFF;
      endcase
   endfunction

   function automatic bit legal(logic [63:0] v, bit uns, bit half);
      longint s;
      s = $signed(v);
      if (half && uns) return (v < 64'd65536);
      if (half)        return (s >= -32768 && s <= 32767);
      return (s >= -64'sd2147483648 && s <= 64'sd2147483647);
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [6:0] f);
      logic [63:0] lhs, prod, r, e_hi, e_lo, e_rd;
      longint sr;
      bit e_err;
      bit acc, hs, un, sa, su, ha, wi;
      {acc, hs, un, sa, su, ha, wi} = f;
      op_start = 1; rs = a; rt = b;
      {f_acc, f_hi_sel, f_uns, f_sat, f_sub, f_half, f_wide} = f;
      // R3 addend, R4 product, R5 add/sub
      lhs = !acc ? 64'h0 : (wi ? m_lo : {m_hi[31:0], m_lo[31:0]});
      if (un) prod = {32'h0, a[31:0]} * {32'h0, b[31:0]};
      else    prod = $unsigned(longint'($signed(a[31:0])) * longint'($signed(b[31:0])));
      r = su ? lhs - prod : lhs + prod;
      sr = $signed(r);
      // R8 R9 clamping
      if (sa && !un && (sr > 64'sd2147483647 || sr < -64'sd2147483648))
         r = (sr < 0) ? 64'hFFFF_FFFF_8000_0000 : 64'h7FFF_FFFF;
      else if (sa && un && r > 64'hFFFF_FFFF)
         r = '1;
      e_err = !(legal(a, un, ha) && legal(b, un, ha));
      if (e_err) begin
         e_hi = m_hi; e_lo = m_lo; e_rd = '0;
      end else if (wi) begin
         e_lo = r; e_hi = m_hi;
         e_rd = hs ? e_hi : e_lo;
      end else begin
         e_lo = {{32{r[31]}}, r[31:0]};
         e_hi = {{32{r[63]}}, r[63:32]};
         e_rd = hs ? e_hi : e_lo;
      end
      @(posedge clk);
      @(negedge clk);
      check(op_done === 1'b1, "R2 done one cycle after start", {63'h0, op_done}, 64'h1);
      check(op_err === e_err, "R10 R11 R12 error flag", {63'h0, op_err}, {63'h0, e_err});
      check(acc_lo === e_lo, wi ? "R7 R3 R4 R5 R8 R9 LO" : "R6 R3 R4 R5 R8 R9 LO", acc_lo, e_lo);
      check(acc_hi === e_hi, e_err ? "R12 HI kept" : (wi ? "R7 HI kept" : "R6 HI"), acc_hi, e_hi);
      check(rd_val === e_rd, e_err ? "R12 rd zero" : "R13 rd select", rd_val, e_rd);
      m_hi = e_hi; m_lo = e_lo;
   endtask

   initial begin
      while (!finished) begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            finish_run();
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      check(acc_hi === '0 && acc_lo === '0, "R1 accumulator in reset", acc_hi | acc_lo, 64'h0);
      check(rd_val === '0 && op_done === 0 && op_err === 0, "R1 outputs in reset", rd_val, 64'h0);
      rst_n = 1;
      @(negedge clk);
      check(acc_hi === '0 && acc_lo === '0 && op_done === 0, "R1 after release", acc_hi | acc_lo, 64'h0);

      for (int fv = 0; fv < 128; fv++) begin
         for (int i = 0; i < NPAT; i++) begin
            for (int j = 0; j < NPAT; j++) begin
               run_op(pat(i), pat(j), 7'(fv));
            end
         end
      end

      // Directed corners after the sweep
      run_op(64'h0, 64'h0, 7'b0000000);                         // clear
      run_op(64'h7FFF_FFFF, 64'h7FFF_FFFF, 7'b0001000);          // R8 positive clamp
      check(acc_lo === 64'h7FFF_FFFF, "R8 positive clamp", acc_lo, 64'h7FFF_FFFF);
      run_op(64'h7FFF_FFFF, 64'hFFFF_FFFF_8000_0000, 7'b0001000); // R8 negative clamp
      check(acc_lo === 64'hFFFF_FFFF_8000_0000, "R8 negative clamp", acc_lo, 64'hFFFF_FFFF_8000_0000);
      run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 7'b0011000);         // R9 unsigned overflow
      check(acc_hi === '1 && acc_lo === '1, "R9 all ones", acc_hi, 64'hFFFF_FFFF_FFFF_FFFF);

      // R2 idle cycle: done falls, accumulator stays
      op_start = 0;
      rs = 64'h1234; rt = 64'h5678;
      @(posedge clk);
      @(negedge clk);
      check(op_done === 1'b0, "R2 no done without start", {63'h0, op_done}, 64'h0);
      check(acc_hi === m_hi && acc_lo === m_lo, "R2 idle hold", acc_lo, m_lo);

      finish_run();
   end
endmodule